// File: doc/BRIEF.md
# Duo-Binary Tail-Biting Turbo Encoder

This block encodes a frame of N two-bit couples (A,B) with two identical eight-state recursive encoders. The first encoder walks the frame in natural order. The second walks it through an interleaver that permutes the indices and exchanges A and B on odd steps. Every couple yields one six-bit symbol: the two systematic bits followed by two parity bits from each encoder.

The frame is loaded one couple per accepted cycle into an internal dual-read memory. A pre-encoding pass then runs both encoders from state zero over the whole frame, reading natural and interleaved addresses in the same cycle. From the two final states and N mod 7 the block derives each encoder's circular start state, so that each encoder ends the frame in the state it began in. A second pass re-reads the frame from those states and streams the symbols out, one per cycle with a valid strobe. After the last couple is accepted, the block needs 2N+4 cycles to finish a frame.

Top module: `turbo_duo_enc`

## Requirements
- R1: Each output symbol is `outSym = {A, B, Y1, W1, Y2, W2}`, with bit 5 = A, bit 4 = B, bit 3 = Y1, bit 2 = W1, bit 1 = Y2 and bit 0 = W2. A and B are the natural couple j of output step j. In the frame memory a couple is stored with A in bit 1 and B in bit 0.
- R2: A constituent encoder with state bits s0, s1, s2 and input couple (a,b) forms f = a^b^s0^s2. It emits y = f^s1^s2 and w = f^s2, then updates s0'=f, s1'=s0^b, s2'=s1^b.
- R3: Y1 and W1 come from encoder 1. Encoder 1 is fed couples 0..N-1 in natural order, starting in its start state.
- R4: Y2 and W2 come from encoder 2. At step j, encoder 2 is fed couple I(j) = (P0*j + Q + 1) mod N, where Q is 0, N/2+P1, P2 or N/2+P3 for j mod 4 = 0, 1, 2 or 3, and N/2 rounds down. When j is odd, A and B are exchanged before the couple enters the encoder.
- R5: When N is not a multiple of 7, each encoder starts in the unique state it returns to after its N couples. When N is a multiple of 7, both encoders start in state 0.
- R6: Frames of any N from 56 to 2396 are encoded. N and P0..P3 are captured when a frame starts, and later changes on those inputs have no effect on that frame.
- R7: While idle, a cycle with inValid and inStart high starts a frame and stores couple 0. The next N-1 cycles with inValid high store couples 1..N-1. inReady is high while idle or loading.
- R8: For each frame, outValid is high for exactly N consecutive cycles and carries steps j = 0..N-1 in order.
- R9: From the last accepted couple until the frame's last symbol, inReady is low and inValid, inStart, inA, inB, nSize and p0..p3 are ignored.
- R10: After reset, outValid is low and inReady is high.
- R11: The first symbol is valid in the (N+5)th cycle after the clock edge that accepts the last couple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Couple on inA/inB is offered |
| inStart | input | 1 | Marks couple 0 of a new frame |
| inA | input | 1 | Information bit A |
| inB | input | 1 | Information bit B |
| nSize | input | 12 | Frame length N in couples |
| p0 | input | 12 | Interleaver step multiplier |
| p1 | input | 12 | Interleaver offset for j mod 4 = 1 |
| p2 | input | 12 | Interleaver offset for j mod 4 = 2 |
| p3 | input | 12 | Interleaver offset for j mod 4 = 3 |
| inReady | output | 1 | Block accepts couples |
| outValid | output | 1 | outSym holds a symbol |
| outSym | output | 6 | Encoded symbol {A,B,Y1,W1,Y2,W2} |

## Verification
On every cycle, the assertions check four things. Both encoders are back in their loaded start states when the output pass ends, which is the tail-biting property. Natural and interleaved read addresses stay below the latched N. No couple is written while the block is busy. Every data beat of the output pass becomes a valid symbol. The parity values themselves, the interleaver permutation with its odd-step swap, and the exact symbol count and latency can only be shown by the bench. It compares every symbol against an independent model that finds the circular states by brute force, over frames of 56, 63, 2396 and random lengths, with and without load gaps and with garbage driven while the block is busy.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_PRE, PH_WAIT, PH_CIRC, PH_OUT, PH_FLUSH
  } phase_t;

  typedef struct packed {
    logic wrEn;      // store couple at idx
    logic rdEn;      // issue natural + interleaved read for step idx
    logic outPass;   // current read belongs to the output pass
    logic loadCirc;  // load circular start states
    logic clearEnc;  // frame accepted: zero the encoders, capture parameters
    logic flush;     // last output-pass data is being consumed
  } ctrlStrb_t;

  function automatic logic [2:0] rscNext(logic [2:0] s, logic a, logic b);
    logic f;
    f = a ^ b ^ s[0] ^ s[2];
    return {s[1] ^ b, s[0] ^ b, f};
  endfunction

  function automatic logic [1:0] rscPar(logic [2:0] s, logic a, logic b);
    logic f;
    f = a ^ b ^ s[0] ^ s[2];
    return {f ^ s[1] ^ s[2], f ^ s[2]};
  endfunction

  // Solve c ^ G^p(c) == fin over the zero-input map G (period 7).
  function automatic logic [2:0] circStart(logic [2:0] fin, logic [2:0] p);
    logic [2:0] res;
    logic [2:0] x;
    res = 3'd0;
    if (p != 3'd0) begin
      for (int c = 0; c < 8; c++) begin
        x = 3'(c);
        for (int k = 0; k < 6; k++)
          if (k < int'(p)) x = rscNext(x, 1'b0, 1'b0);
        if ((x ^ 3'(c)) == fin) res = 3'(c);
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/tbe_rsc.sv
module tbe_rsc
  import tbe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       load,
  input  logic [2:0] loadVal,
  input  logic       step,
  input  logic       a,
  input  logic       b,
  output logic [2:0] state,
  output logic       y,
  output logic       w
);

  always_ff @(posedge clk) begin
    if (!rstN)      state <= 3'd0;
    else if (clear) state <= 3'd0;
    else if (load)  state <= loadVal;
    else if (step)  state <= rscNext(state, a, b);
  end

  assign {y, w} = rscPar(state, a, b);

endmodule

// File: rtl/tbe_agu.sv
module tbe_agu #(
  parameter int NW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          capture,
  input  logic          advance,
  input  logic [NW-1:0] nSize,
  input  logic [NW-1:0] nLat,
  input  logic [NW-1:0] p0,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  input  logic [1:0]    sel,
  output logic [NW-1:0] addrInt
);

  localparam int EW = NW + 1;

  logic [NW-1:0] p0r;
  logic [NW-1:0] offs [4];
  logic [NW-1:0] acc;
  logic [EW-1:0] rawOff [4];
  logic [EW-1:0] accSum, addrSum;

  always_comb begin
    rawOff[0] = EW'(1);
    rawOff[1] = EW'(nSize >> 1) + EW'(p1) + EW'(1);
    rawOff[2] = EW'(p2) + EW'(1);
    rawOff[3] = EW'(nSize >> 1) + EW'(p3) + EW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p0r <= '0;
      for (int k = 0; k < 4; k++) offs[k] <= '0;
    end else if (capture) begin
      p0r <= NW'(p0 % nSize);
      for (int k = 0; k < 4; k++) offs[k] <= NW'(rawOff[k] % EW'(nSize));
    end
  end

  // acc tracks (P0 * j) mod N for the step being read
  assign accSum  = EW'(acc) + EW'(p0r);
  assign addrSum = EW'(acc) + EW'(offs[sel]);

  always_ff @(posedge clk) begin
    if (!rstN || !advance) acc <= '0;
    else acc <= (accSum >= EW'(nLat)) ? NW'(accSum - EW'(nLat)) : NW'(accSum);
  end

  assign addrInt = (addrSum >= EW'(nLat)) ? NW'(addrSum - EW'(nLat)) : NW'(addrSum);

  // R4: interleaved address lies inside the frame
  p_int_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> (addrInt < nLat));

endmodule

// File: rtl/tbe_ctrl.sv
module tbe_ctrl
  import tbe_pkg::*;
#(
  parameter int NW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inStart,
  input  logic [NW-1:0] nSize,
  output logic          inReady,
  output ctrlStrb_t     strb,
  output logic [NW-1:0] idx,
  output logic [NW-1:0] nLat
);

  phase_t phase;
  logic   lastIdx;
  logic   startHit;

  assign lastIdx  = (idx == nLat - NW'(1));
  assign inReady  = (phase == PH_IDLE) || (phase == PH_LOAD);
  assign startHit = inValid && inStart && (phase == PH_IDLE);

  always_comb begin
    strb          = '0;
    strb.clearEnc = startHit;
    strb.wrEn     = startHit || (inValid && phase == PH_LOAD);
    strb.rdEn     = (phase == PH_PRE) || (phase == PH_OUT);
    strb.outPass  = (phase == PH_OUT);
    strb.loadCirc = (phase == PH_CIRC);
    strb.flush    = (phase == PH_FLUSH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
      nLat  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (startHit) begin
          nLat  <= nSize;
          idx   <= NW'(1);
          phase <= PH_LOAD;
        end
        PH_LOAD: if (inValid) begin
          if (lastIdx) begin idx <= '0; phase <= PH_PRE; end
          else idx <= idx + NW'(1);
        end
        PH_PRE: begin
          if (lastIdx) begin idx <= '0; phase <= PH_WAIT; end
          else idx <= idx + NW'(1);
        end
        PH_WAIT: phase <= PH_CIRC;
        PH_CIRC: phase <= PH_OUT;
        PH_OUT: begin
          if (lastIdx) begin idx <= '0; phase <= PH_FLUSH; end
          else idx <= idx + NW'(1);
        end
        PH_FLUSH: phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  // R6: natural read address stays inside the latched frame
  p_nat_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> (idx < nLat));

  // R9: no couple is stored while the block refuses input
  p_busy_refuse_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> !strb.wrEn);

endmodule

// File: rtl/tbe_datapath.sv
module tbe_datapath
  import tbe_pkg::*;
#(
  parameter int MAX_N = 2396,
  parameter int NW    = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [NW-1:0] idx,
  input  logic [NW-1:0] nLat,
  input  logic [NW-1:0] nSize,
  input  logic [NW-1:0] p0,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  input  logic          inA,
  input  logic          inB,
  output logic          outValid,
  output logic [5:0]    outSym
);

  logic [1:0]    mem [MAX_N];
  logic [1:0]    memNatQ, memIntQ;
  logic [NW-1:0] addrInt;
  logic          swapQ, rdValidQ, rdOutQ, flushQ;
  logic [2:0]    nMod7;
  logic [1:0][1:0] coupleSel;
  logic [1:0][2:0] encState;
  logic [1:0][2:0] circQ;
  logic [1:0]      parY, parW;

  tbe_agu #(.NW(NW)) u_agu (
    .clk(clk), .rstN(rstN), .capture(strb.clearEnc), .advance(strb.rdEn),
    .nSize(nSize), .nLat(nLat), .p0(p0), .p1(p1), .p2(p2), .p3(p3),
    .sel(idx[1:0]), .addrInt(addrInt)
  );

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[idx] <= {inA, inB};
    memNatQ <= mem[idx];
    memIntQ <= mem[addrInt];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swapQ    <= 1'b0;
      rdValidQ <= 1'b0;
      rdOutQ   <= 1'b0;
      flushQ   <= 1'b0;
      nMod7    <= 3'd0;
    end else begin
      swapQ    <= idx[0];
      rdValidQ <= strb.rdEn;
      rdOutQ   <= strb.outPass;
      flushQ   <= strb.flush;
      if (strb.clearEnc) nMod7 <= 3'(nSize % NW'(7));
    end
  end

  assign coupleSel[0] = memNatQ;
  assign coupleSel[1] = swapQ ? {memIntQ[0], memIntQ[1]} : memIntQ;

  for (genvar g = 0; g < 2; g++) begin : g_enc
    tbe_rsc u_rsc (
      .clk(clk), .rstN(rstN), .clear(strb.clearEnc), .load(strb.loadCirc),
      .loadVal(circStart(encState[g], nMod7)), .step(rdValidQ),
      .a(coupleSel[g][1]), .b(coupleSel[g][0]),
      .state(encState[g]), .y(parY[g]), .w(parW[g])
    );

    always_ff @(posedge clk) begin
      if (!rstN) circQ[g] <= 3'd0;
      else if (strb.loadCirc) circQ[g] <= circStart(encState[g], nMod7);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSym   <= '0;
    end else begin
      outValid <= rdValidQ && rdOutQ;
      if (rdValidQ && rdOutQ)
        outSym <= {memNatQ, parY[0], parW[0], parY[1], parW[1]};
    end
  end

  // R5: both encoders end the output pass in their start state
  p_tailbite_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flushQ && nMod7 != 3'd0) |-> (encState[0] == circQ[0] && encState[1] == circQ[1]));

  // R8: every output-pass data beat becomes a valid symbol
  p_beat_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValidQ && rdOutQ) |=> outValid);

endmodule

// File: rtl/turbo_duo_enc.sv
module turbo_duo_enc
  import tbe_pkg::*;
#(
  parameter  int MAX_N = 2396,
  localparam int NW    = $clog2(MAX_N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inStart,
  input  logic          inA,
  input  logic          inB,
  input  logic [NW-1:0] nSize,
  input  logic [NW-1:0] p0,
  input  logic [NW-1:0] p1,
  input  logic [NW-1:0] p2,
  input  logic [NW-1:0] p3,
  output logic          inReady,
  output logic          outValid,
  output logic [5:0]    outSym
);

  ctrlStrb_t     strb;
  logic [NW-1:0] idx;
  logic [NW-1:0] nLat;

  tbe_ctrl #(.NW(NW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .nSize(nSize), .inReady(inReady), .strb(strb), .idx(idx), .nLat(nLat)
  );

  tbe_datapath #(.MAX_N(MAX_N), .NW(NW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .nLat(nLat),
    .nSize(nSize), .p0(p0), .p1(p1), .p2(p2), .p3(p3),
    .inA(inA), .inB(inB), .outValid(outValid), .outSym(outSym)
  );

endmodule

// File: tb/tb_turbo_duo_enc.sv
`timescale 1ns/1ps
module tb_turbo_duo_enc;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inStart = 1'b0, inA = 1'b0, inB = 1'b0;
  logic [11:0] nSize = 12'd56, p0 = '0, p1 = '0, p2 = '0, p3 = '0;
  logic inReady, outValid;
  logic [5:0] outSym;

  int checks = 0, failures = 0;
  logic [1:0] frm [2396];
  logic [5:0] expSym [2396];
  int vP0, vP1, vP2, vP3;

  always #2.5 clk = ~clk;

  turbo_duo_enc dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inA(inA), .inB(inB),
    .nSize(nSize), .p0(p0), .p1(p1), .p2(p2), .p3(p3),
    .inReady(inReady), .outValid(outValid), .outSym(outSym)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] mNext(logic [2:0] s, logic a, logic b);
    logic f;
    f = a ^ b ^ s[0] ^ s[2];
    return {s[1] ^ b, s[0] ^ b, f};
  endfunction

  function automatic logic [1:0] mPar(logic [2:0] s, logic a, logic b);
    logic f;
    f = a ^ b ^ s[0] ^ s[2];
    return {f ^ s[1] ^ s[2], f ^ s[2]};
  endfunction

  function automatic logic [1:0] intCouple(int n, int j);
    int q, ix;
    logic [1:0] c;
    case (j % 4)
      0: q = 0;
      1: q = n / 2 + vP1;
      2: q = vP2;
      default: q = n / 2 + vP3;
    endcase
    ix = (vP0 * j + q + 1) % n;
    c = frm[ix];
    return (j % 2 == 1) ? {c[0], c[1]} : c;
  endfunction

  function automatic logic [1:0] couple(int n, int j, bit useInt);
    return useInt ? intCouple(n, j) : frm[j];
  endfunction

  function automatic logic [2:0] runEnc(int n, logic [2:0] s0, bit useInt);
    logic [2:0] s;
    logic [1:0] c;
    s = s0;
    for (int j = 0; j < n; j++) begin
      c = couple(n, j, useInt);
      s = mNext(s, c[1], c[0]);
    end
    return s;
  endfunction

  function automatic logic [2:0] findCirc(int n, bit useInt);
    logic [2:0] r;
    r = 3'd0;
    if (n % 7 != 0)
      for (int c = 0; c < 8; c++)
        if (runEnc(n, 3'(c), useInt) == 3'(c)) r = 3'(c);
    return r;
  endfunction

  task automatic buildExpected(int n);
    logic [2:0] s1, s2;
    logic [1:0] nc, ic;
    s1 = findCirc(n, 1'b0);
    s2 = findCirc(n, 1'b1);
    for (int j = 0; j < n; j++) begin
      nc = frm[j];
      ic = intCouple(n, j);
      expSym[j] = {nc, mPar(s1, nc[1], nc[0]), mPar(s2, ic[1], ic[0])};
      s1 = mNext(s1, nc[1], nc[0]);
      s2 = mNext(s2, ic[1], ic[0]);
    end
  endtask

  task automatic runFrame(int n, bit gaps);
    int i, k, got, firstK;
    for (int j = 0; j < n; j++) frm[j] = 2'($urandom);
    vP0 = int'($urandom_range(4095)); vP1 = int'($urandom_range(4095));
    vP2 = int'($urandom_range(4095)); vP3 = int'($urandom_range(4095));
    buildExpected(n);

    @(negedge clk);
    check(inReady == 1'b1, "R7 ready before frame", int'(inReady), 1);
    inValid = 1'b1; inStart = 1'b1; {inA, inB} = frm[0];
    nSize = 12'(n); p0 = 12'(vP0); p1 = 12'(vP1); p2 = 12'(vP2); p3 = 12'(vP3);
    @(posedge clk);
    i = 1;
    while (i < n) begin
      @(negedge clk);
      inStart = 1'b0;
      if (gaps && $urandom_range(3) == 0) begin
        inValid = 1'b0; {inA, inB} = 2'($urandom);
      end else begin
        inValid = 1'b1; {inA, inB} = frm[i];
      end
      @(posedge clk);
      if (inValid) i++;
    end

    k = 0; got = 0; firstK = -1;
    while (got < n && k < 3 * n + 50) begin
      @(negedge clk);
      k++;
      if (k == 1) check(inReady == 1'b0, "R9 ready low while busy", int'(inReady), 0);
      if (k <= n) begin
        inValid = 1'b1; inStart = 1'b1; {inA, inB} = 2'($urandom);
        nSize = 12'($urandom_range(56, 2396)); p0 = 12'($urandom); p2 = 12'($urandom);
      end else begin
        inValid = 1'b0; inStart = 1'b0;
      end
      if (outValid) begin
        if (firstK < 0) begin
          firstK = k;
          check(k == n + 5, "R11 first symbol latency", k, n + 5);
        end
        check(outSym[5:4] == expSym[got][5:4], "R1 systematic bits", int'(outSym[5:4]), int'(expSym[got][5:4]));
        check(outSym[3:2] == expSym[got][3:2], "R2/R3/R5 natural parity", int'(outSym[3:2]), int'(expSym[got][3:2]));
        check(outSym[1:0] == expSym[got][1:0], "R4/R5/R6 interleaved parity", int'(outSym[1:0]), int'(expSym[got][1:0]));
        got++;
      end else if (got > 0) begin
        check(1'b0, "R8 gap inside symbol burst", got, n);
      end
    end
    check(got == n, "R6/R8 symbol count", got, n);
    @(negedge clk);
    check(outValid == 1'b0, "R8 valid drops after N symbols", int'(outValid), 0);
    check(inReady == 1'b1, "R9 ready again after frame", int'(inReady), 1);
  endtask

  initial begin
    void'($urandom(32'h7c15));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R10 valid low in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R10 ready after reset", int'(inReady), 1);
    check(outValid == 1'b0, "R10 valid low after reset", int'(outValid), 0);
    // R9: start pulse without inValid must not begin a frame
    inStart = 1'b1;
    @(negedge clk);
    inStart = 1'b0;
    check(inReady == 1'b1 && outValid == 1'b0, "R9 start without valid", int'(outValid), 0);

    runFrame(56, 1'b0);                  // R6 lower bound, multiple of 7 (R5)
    runFrame(2396, 1'b1);                // R6 upper bound
    runFrame(63, 1'b1);                  // R5 multiple of 7
    runFrame(57, 1'b0);
    for (int f = 0; f < 4; f++) begin
      int n;
      n = int'($urandom_range(58, 700));
      if (n % 7 == 0) n++;
      runFrame(n, f[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule